// File: doc/BRIEF.md
# Version String Streaming Register

This block serves a fixed-length identification string to a host one character at a time through a single register address. The string storage is loaded by local firmware through a separate load port. A host read of that address asks for N bytes. The block then delivers the next N characters of the string from an internal read index, one per clock.

A host write to the same address puts the index back at the start of the string. The write data is not examined. When the read reaches the terminating NUL character, the index stops there. Further reads then return zero bytes until the next write rewinds it. If the index reaches the end of storage, every byte returned is zero as well.

A host request is taken only while no burst is in flight. The byte stream is marked by a valid strobe and has no backpressure.

Top module: `verstr_stream`

## Requirements
- R1: After reset the byte stream is idle (byteValid low, byteData 0x00), the read index is zero and every storage byte is 0x00, so a read then returns only zero bytes.
- R2: A read request (reqValid high, reqWrite low, reqAddr equal to REG_ADDR, default 0xF90) with a count N from 1 to 64, taken while the stream is idle, drives byteValid high for exactly N consecutive cycles, starting in the cycle after the request edge.
- R3: The bytes of a burst are the stored characters in increasing index order, starting at the current read index.
- R4: The read index advances by one after a delivered byte only when that byte is nonzero. A NUL byte leaves the index where it is, so later bytes repeat 0x00.
- R5: When the read index equals STR_LEN (80), every delivered byte is 0x00, and the index never exceeds 80.
- R6: A write request (reqWrite high) to REG_ADDR, taken while idle, sets the read index to zero. No bytes are streamed for a write.
- R7: A read count of 0 streams no bytes. A count above 64 streams exactly 64 bytes.
- R8: A request to any other address is ignored, and so is any request while a burst is in flight. Neither changes the index or the stream.
- R9: A load (loadValid high) writes loadData into storage entry loadAddr when loadAddr is below 80, and is ignored otherwise. A load never moves the read index. byteData is 0x00 whenever byteValid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host register access strobe |
| reqWrite | input | 1 | 1 = write (rewind), 0 = read |
| reqAddr | input | 12 | Register address of the access |
| reqCount | input | 7 | Bytes requested by a read |
| loadValid | input | 1 | Storage load strobe |
| loadAddr | input | 7 | Storage entry to load |
| loadData | input | 8 | Character to store |
| byteValid | output | 1 | A streamed byte is present |
| byteData | output | 8 | Streamed byte |

## Verification
Each request is sampled at a clock edge. The first byte of a read is valid in the cycle that starts at that edge. Each following byte arrives one cycle later. A rewind or a load takes effect on the byte delivered in the cycle after its edge. The bench drives inputs and compares both outputs at the falling edge. It updates its behavioural model with the inputs that the coming rising edge will sample, so every comparison is made against the model's value for the current cycle.

// File: rtl/vsr_pkg.sv
package vsr_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic rewind;  // return read index to zero
    logic shift;   // a byte is delivered this cycle
  } ctrlStrobeT;
endpackage

// File: rtl/vsr_ctrl.sv
module vsr_ctrl
  import vsr_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] REG_ADDR = 12'hF90,
  parameter int MAX_BURST = 64,
  parameter int CNT_W     = $clog2(MAX_BURST + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [CNT_W-1:0]  reqCount,
  output ctrlStrobeT        strobes,
  output logic              streamOn
);
  logic [CNT_W-1:0] remaining;
  logic             idle;
  logic             hit;
  logic [CNT_W-1:0] clampCount;

  assign idle = (remaining == '0);
  assign hit  = reqValid && (reqAddr == REG_ADDR) && idle;
  assign clampCount = (reqCount > CNT_W'(MAX_BURST)) ? CNT_W'(MAX_BURST) : reqCount;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remaining <= '0;
    end else if (!idle) begin
      remaining <= remaining - 1'b1;
    end else if (hit && !reqWrite) begin
      remaining <= clampCount;
    end
  end

  always_comb begin
    strobes.rewind = hit && reqWrite;
    strobes.shift  = !idle;
  end

  assign streamOn = !idle;
endmodule

// File: rtl/vsr_data.sv
module vsr_data
  import vsr_pkg::*;
#(
  parameter int STR_LEN = 80,
  parameter int IDX_W   = $clog2(STR_LEN + 1),
  parameter int LA_W    = $clog2(STR_LEN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobeT       strobes,
  input  logic             loadValid,
  input  logic [LA_W-1:0]  loadAddr,
  input  logic [7:0]       loadData,
  output logic [7:0]       byteData,
  output logic [IDX_W-1:0] readIdx
);
  logic [7:0] charMem [STR_LEN];
  logic [7:0] curChar;
  logic       inRange;

  // one storage register per character
  for (genvar gi = 0; gi < STR_LEN; gi++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        charMem[gi] <= 8'h00;
      end else if (loadValid && (loadAddr == LA_W'(gi))) begin
        charMem[gi] <= loadData;
      end
    end
  end

  assign inRange = (readIdx < IDX_W'(STR_LEN));

  always_comb begin
    curChar = 8'h00;
    if (inRange) begin
      curChar = charMem[readIdx[LA_W-1:0]];
    end
  end

  assign byteData = strobes.shift ? curChar : 8'h00;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readIdx <= '0;
    end else if (strobes.rewind) begin
      readIdx <= '0;
    end else if (strobes.shift && inRange && (curChar != 8'h00)) begin
      readIdx <= readIdx + 1'b1;
    end
  end
endmodule

// File: rtl/verstr_stream.sv
module verstr_stream
  import vsr_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] REG_ADDR = 12'hF90,
  parameter int STR_LEN   = 80,
  parameter int MAX_BURST = 64,
  parameter int CNT_W     = $clog2(MAX_BURST + 1),
  parameter int LA_W      = $clog2(STR_LEN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [CNT_W-1:0]  reqCount,
  input  logic              loadValid,
  input  logic [LA_W-1:0]   loadAddr,
  input  logic [7:0]        loadData,
  output logic              byteValid,
  output logic [7:0]        byteData
);
  localparam int IDX_W = $clog2(STR_LEN + 1);

  ctrlStrobeT       strobes;
  logic [IDX_W-1:0] readIdx;

  vsr_ctrl #(
    .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .MAX_BURST(MAX_BURST), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqCount(reqCount), .strobes(strobes),
    .streamOn(byteValid)
  );

  vsr_data #(
    .STR_LEN(STR_LEN), .IDX_W(IDX_W), .LA_W(LA_W)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .loadValid(loadValid),
    .loadAddr(loadAddr), .loadData(loadData), .byteData(byteData),
    .readIdx(readIdx)
  );
endmodule

// File: rtl/vsr_checker.sv
module vsr_checker #(
  parameter int ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] REG_ADDR = 12'hF90,
  parameter int STR_LEN   = 80,
  parameter int MAX_BURST = 64,
  parameter int CNT_W     = 7,
  parameter int IDX_W     = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [CNT_W-1:0]  reqCount,
  input logic              byteValid,
  input logic [7:0]        byteData,
  input logic [IDX_W-1:0]  readIdx
);
  logic [CNT_W:0] runLen;

  always_ff @(posedge clk) begin
    if (!rstN) runLen <= '0;
    else if (byteValid) runLen <= runLen + 1'b1;
    else runLen <= '0;
  end

  logic takeRead, takeWrite;
  assign takeRead  = reqValid && !reqWrite && (reqAddr == REG_ADDR) && !byteValid;
  assign takeWrite = reqValid && reqWrite && (reqAddr == REG_ADDR) && !byteValid;

  AST_BURST_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> (runLen < (CNT_W+1)'(MAX_BURST))); // R7
  AST_READ_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    (takeRead && reqCount != '0) |=> byteValid); // R2
  AST_NUL_STICKS: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && byteData == 8'h00) |=> $stable(readIdx)); // R4
  AST_CHAR_ADVANCES: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && byteData != 8'h00) |=> (readIdx == $past(readIdx) + 1'b1)); // R4
  AST_IDX_CEILING: assert property (@(posedge clk) disable iff (!rstN)
    readIdx <= IDX_W'(STR_LEN)); // R5
  AST_END_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && readIdx == IDX_W'(STR_LEN)) |-> byteData == 8'h00); // R5
  AST_REWIND: assert property (@(posedge clk) disable iff (!rstN)
    takeWrite |=> (readIdx == '0 && !byteValid)); // R6
  AST_IDLE_DATA: assert property (@(posedge clk) disable iff (!rstN)
    !byteValid |-> byteData == 8'h00); // R9
endmodule

bind verstr_stream vsr_checker #(
  .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .STR_LEN(STR_LEN),
  .MAX_BURST(MAX_BURST), .CNT_W(CNT_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .reqAddr(reqAddr), .reqCount(reqCount), .byteValid(byteValid),
  .byteData(byteData), .readIdx(readIdx)
);

// File: tb/test_verstr_stream.sv
module test_verstr_stream;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [11:0] reqAddr = '0;
  logic [6:0]  reqCount = '0;
  logic        loadValid = 1'b0;
  logic [6:0]  loadAddr = '0;
  logic [7:0]  loadData = '0;
  logic        byteValid;
  logic [7:0]  byteData;

  always #10 clk = ~clk;  // 50 MHz

  verstr_stream i_verstr_stream (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqCount(reqCount), .loadValid(loadValid),
    .loadAddr(loadAddr), .loadData(loadData), .byteValid(byteValid),
    .byteData(byteData)
  );

  int checks = 0;
  int failures = 0;
  string curTag = "R1";
  bit done = 0;

  // behavioural reference
  byte unsigned refMem[80];
  int refIdx = 0;
  int refRem = 0;

  task automatic compareNow();
    bit expV;
    byte unsigned expD;
    expV = (refRem > 0);
    expD = 0;
    if (expV && refIdx < 80) expD = refMem[refIdx];
    checks++;
    if (byteValid !== expV || byteData !== expD) begin
      failures++;
      $display("FAIL %s: valid=%0b data=%02h expected valid=%0b data=%02h",
               curTag, byteValid, byteData, expV, expD);
    end
  endtask

  task automatic tick(input bit rv, input bit rw, input int ad, input int cn,
                      input bit lv, input int la, input int ld);
    byte unsigned d;
    @(negedge clk);
    compareNow();
    reqValid = rv; reqWrite = rw; reqAddr = 12'(ad); reqCount = 7'(cn);
    loadValid = lv; loadAddr = 7'(la); loadData = 8'(ld);
    // model state for the coming edge
    if (refRem > 0) begin
      d = (refIdx < 80) ? refMem[refIdx] : 8'h00;
      if (d != 0 && refIdx < 80) refIdx++;
      refRem--;
    end else if (rv && ad == 'hF90) begin
      if (rw) refIdx = 0;
      else refRem = (cn > 64) ? 64 : cn;
    end
    if (lv && la < 80) refMem[la] = 8'(ld);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic rd(input int n);
    tick(1, 0, 'hF90, n, 0, 0, 0);
    idle((n > 64 ? 64 : n) + 1);
  endtask

  task automatic rewind();
    tick(1, 1, 'hF90, 0, 0, 0, 0);
    idle(1);
  endtask

  task automatic loadStr(input string s);
    for (int i = 0; i < s.len(); i++) tick(0, 0, 0, 0, 1, i, s[i]);
    tick(0, 0, 0, 0, 1, s.len(), 0);
  endtask

  initial begin
    for (int i = 0; i < 80; i++) refMem[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    curTag = "R1"; idle(2); rd(5);
    curTag = "R9"; loadStr("VER-1.2 build");
    tick(0, 0, 0, 0, 1, 100, 'h55);  // out of range load, ignored
    curTag = "R2"; rd(4);
    curTag = "R3"; rd(6);
    curTag = "R4"; rd(12); rd(3);
    curTag = "R6"; rewind(); rd(6);
    curTag = "R8";
    tick(1, 0, 'hF91, 8, 0, 0, 0); idle(3);
    tick(1, 1, 'h000, 0, 0, 0, 0); idle(1);
    tick(1, 0, 'hF90, 10, 0, 0, 0);
    tick(1, 1, 'hF90, 0, 0, 0, 0);
    tick(1, 0, 'hF90, 30, 0, 0, 0);
    idle(10);
    curTag = "R7"; rewind(); tick(1, 0, 'hF90, 0, 0, 0, 0); idle(3);
    rewind(); rd(100);
    curTag = "R9";
    rewind();
    tick(1, 0, 'hF90, 8, 0, 0, 0);
    tick(0, 0, 0, 0, 1, 2, 'h5A);
    tick(0, 0, 0, 0, 1, 3, 'h00);
    idle(8);
    curTag = "R5";
    for (int i = 0; i < 80; i++) tick(0, 0, 0, 0, 1, i, 'h41 + (i % 26));
    rewind(); rd(64); rd(30); rd(5);
    curTag = "R1";
    @(negedge clk); rstN = 1'b0;
    for (int i = 0; i < 80; i++) refMem[i] = 0;
    refIdx = 0; refRem = 0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
    idle(1); rd(4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule